// File: doc/BRIEF.md
# Halt group trigger engine

This block ties several harts and external trigger lines into debug halt groups. Each hart and each external trigger holds a small group number. When a member hart reports a fresh halt, or a member trigger input rises, its group becomes "fired". While a group is fired, every hart in it receives a halt interrupt and every trigger in it has its outgoing request raised. The hart that caused the firing is included. The fired state clears only once every member hart is halted and every member trigger has acknowledged.

Group numbers are set and inspected through a single configuration access. The access carries a write flag, a target-kind flag (harts or trigger), a group value, a trigger index, the mask of selected harts and the currently selected hart. Group 0 is the ungrouped default: its members never take part in group halting. The halt interrupt output is meant to be ORed with the other halt sources of each hart outside this block.

Top module: `halt_group_engine`

## Requirements
- R1: After reset, all harts and triggers belong to group 0, no halt interrupt or trigger-out request is asserted, and a read returns 0 in both target kinds.
- R2: An access with `cfg_valid`=1, `cfg_write`=1 and `cfg_sel_trig`=0 sets the group of every hart whose bit is set in `hart_sel_mask`, effective from the next cycle. Other harts keep their group.
- R3: An access with `cfg_valid`=1, `cfg_write`=1 and `cfg_sel_trig`=1 sets the group only of the trigger numbered `cfg_trig_idx`.
- R4: An access with `cfg_write`=0 changes no group. A write whose 3-bit group value is 4 or greater (beyond the 4 groups) also changes no group.
- R5: `cfg_rd_group` combinationally returns the group of hart `hart_sel_id` when `cfg_sel_trig`=0, and the group of trigger `cfg_trig_idx` when `cfg_sel_trig`=1, zero-extended to 3 bits.
- R6: A cycle with `halt_evt`=1 fires the group of hart `halt_evt_id` if `halted[halt_evt_id]` is 0 in that cycle. From the next cycle, every hart of that group, including the reporter, has `grp_halt_irq` high, and every trigger of that group has `trig_out_req` high. An event for a hart whose halted bit is already 1 fires nothing.
- R7: A 0-to-1 transition of `trig_in[t]` between consecutive cycles fires the group of trigger t. A level held high does not fire again.
- R8: A fired group stays fired while any member hart has its `halted` bit at 0 or any member trigger has `trig_out_ack` at 0. In the cycle after all members satisfy both, the group clears. Its halt interrupts and trigger-out requests drop in that same cycle. Clearing takes priority over a new firing in the same cycle.
- R9: Group 0 never fires. A hart or trigger in group 0 never sees its interrupt or request raised.
- R10: Firing one group leaves the outputs of harts and triggers in other groups unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration access present this cycle |
| cfg_write | input | 1 | Access writes the group value |
| cfg_sel_trig | input | 1 | 0: access targets harts, 1: a trigger |
| cfg_group | input | 3 | Group value to write |
| cfg_trig_idx | input | 1 | Trigger targeted by the access |
| hart_sel_mask | input | 4 | Harts selected for a hart-group write |
| hart_sel_id | input | 2 | Hart whose group is read back |
| cfg_rd_group | output | 3 | Group read back |
| halt_evt | input | 1 | A hart reports it has halted |
| halt_evt_id | input | 2 | Reporting hart |
| halted | input | 4 | Current halted state per hart |
| trig_in | input | 2 | External trigger input requests |
| trig_out_ack | input | 2 | Acknowledge of each trigger-out |
| grp_halt_irq | output | 4 | Group halt interrupt per hart |
| trig_out_req | output | 2 | Trigger-out request per trigger |

## Verification
The bench builds the block with its defaults: 4 harts, 2 triggers, 4 groups and a 3-bit group field. With these values, three groups can fire while group 0 stays silent. Two harts can share a group while a third sits in another group. Each trigger can join a hart group. The spare values 4 to 7 of the field test the ignored out-of-range writes. With this small population, random halt events, trigger edges and acknowledges often complete a group and clear it, so both firing and clearing are exercised many times.

// File: rtl/halt_group_engine.sv
module halt_group_engine #(
  parameter int NUM_HARTS  = 4,
  parameter int NUM_TRIGS  = 2,
  parameter int NUM_GROUPS = 4,
  parameter int GF_W       = 3,
  localparam int HID_W = (NUM_HARTS  > 1) ? $clog2(NUM_HARTS)  : 1,
  localparam int TID_W = (NUM_TRIGS  > 1) ? $clog2(NUM_TRIGS)  : 1,
  localparam int GW    = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_valid,
  input  logic                 cfg_write,
  input  logic                 cfg_sel_trig,
  input  logic [GF_W-1:0]      cfg_group,
  input  logic [TID_W-1:0]     cfg_trig_idx,
  input  logic [NUM_HARTS-1:0] hart_sel_mask,
  input  logic [HID_W-1:0]     hart_sel_id,
  output logic [GF_W-1:0]      cfg_rd_group,
  input  logic                 halt_evt,
  input  logic [HID_W-1:0]     halt_evt_id,
  input  logic [NUM_HARTS-1:0] halted,
  input  logic [NUM_TRIGS-1:0] trig_in,
  input  logic [NUM_TRIGS-1:0] trig_out_ack,
  output logic [NUM_HARTS-1:0] grp_halt_irq,
  output logic [NUM_TRIGS-1:0] trig_out_req
);

  localparam logic [GF_W:0] GROUP_LIMIT = (GF_W+1)'(NUM_GROUPS);

  logic [NUM_HARTS-1:0][GW-1:0] hart_grp;
  logic [NUM_TRIGS-1:0][GW-1:0] trig_grp;
  logic [NUM_TRIGS-1:0]         trig_prev;
  logic [NUM_GROUPS-1:1]        fired_q;
  logic [NUM_GROUPS-1:0]        fired;
  logic                         wr_ok;
  logic                         evt_fresh;
  logic [GW-1:0]                rd_sel;

  assign wr_ok     = cfg_valid && cfg_write && ({1'b0, cfg_group} < GROUP_LIMIT);
  assign evt_fresh = halt_evt && !halted[halt_evt_id];
  assign fired     = {fired_q, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hart_grp  <= '0;
      trig_grp  <= '0;
      trig_prev <= '0;
    end else begin
      trig_prev <= trig_in;
      for (int h = 0; h < NUM_HARTS; h++)
        if (wr_ok && !cfg_sel_trig && hart_sel_mask[h])
          hart_grp[h] <= cfg_group[GW-1:0];
      for (int t = 0; t < NUM_TRIGS; t++)
        if (wr_ok && cfg_sel_trig && (cfg_trig_idx == TID_W'(t)))
          trig_grp[t] <= cfg_group[GW-1:0];
    end
  end

  always_comb begin
    rd_sel = '0;
    if (cfg_sel_trig) begin
      for (int t = 0; t < NUM_TRIGS; t++)
        if (cfg_trig_idx == TID_W'(t)) rd_sel = trig_grp[t];
    end else begin
      for (int h = 0; h < NUM_HARTS; h++)
        if (hart_sel_id == HID_W'(h)) rd_sel = hart_grp[h];
    end
  end
  assign cfg_rd_group = GF_W'(rd_sel);

  for (genvar g = 1; g < NUM_GROUPS; g++) begin : g_group
    logic hart_hit, trig_hit, all_halted, all_acked;

    always_comb begin
      hart_hit   = evt_fresh && (hart_grp[halt_evt_id] == GW'(g));
      trig_hit   = 1'b0;
      all_halted = 1'b1;
      all_acked  = 1'b1;
      for (int h = 0; h < NUM_HARTS; h++)
        if (hart_grp[h] == GW'(g) && !halted[h]) all_halted = 1'b0;
      for (int t = 0; t < NUM_TRIGS; t++)
        if (trig_grp[t] == GW'(g)) begin
          if (trig_in[t] && !trig_prev[t]) trig_hit = 1'b1;
          if (!trig_out_ack[t]) all_acked = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                                  fired_q[g] <= 1'b0;
      else if (fired_q[g] && all_halted && all_acked) fired_q[g] <= 1'b0;
      else if (hart_hit || trig_hit)               fired_q[g] <= 1'b1;
    end
  end

  always_comb begin
    for (int h = 0; h < NUM_HARTS; h++) grp_halt_irq[h] = fired[hart_grp[h]];
    for (int t = 0; t < NUM_TRIGS; t++) trig_out_req[t] = fired[trig_grp[t]];
  end

endmodule

// File: rtl/halt_group_engine_checker.sv
module halt_group_engine_checker #(
  parameter int NUM_HARTS  = 4,
  parameter int NUM_TRIGS  = 2,
  parameter int NUM_GROUPS = 4,
  localparam int HID_W = (NUM_HARTS  > 1) ? $clog2(NUM_HARTS)  : 1,
  localparam int GW    = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_valid,
  input logic                         cfg_write,
  input logic                         halt_evt,
  input logic [HID_W-1:0]             halt_evt_id,
  input logic [NUM_HARTS-1:0]         halted,
  input logic [NUM_TRIGS-1:0]         trig_in,
  input logic [NUM_TRIGS-1:0]         trig_out_ack,
  input logic [NUM_HARTS-1:0]         grp_halt_irq,
  input logic [NUM_TRIGS-1:0]         trig_out_req,
  input logic [NUM_HARTS-1:0][GW-1:0] hart_grp,
  input logic [NUM_TRIGS-1:0][GW-1:0] trig_grp
);

  logic no_wr;
  assign no_wr = !(cfg_valid && cfg_write);

  assert_reporter_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_evt && !halted[halt_evt_id] && hart_grp[halt_evt_id] != '0 && no_wr)
      |=> grp_halt_irq[$past(halt_evt_id)]);

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_h
    assert_irq_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_halt_irq[h] && !halted[h] && no_wr) |=> grp_halt_irq[h]);
    assert_group0_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hart_grp[h] == '0) |-> !grp_halt_irq[h]);
  end

  for (genvar t = 0; t < NUM_TRIGS; t++) begin : g_t
    assert_edge_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(trig_in[t]) && !trig_out_req[t] && trig_grp[t] != '0 && no_wr)
        |=> trig_out_req[t]);
    assert_req_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_out_req[t] && !trig_out_ack[t] && no_wr) |=> trig_out_req[t]);
  end

endmodule

bind halt_group_engine halt_group_engine_checker #(
  .NUM_HARTS(NUM_HARTS), .NUM_TRIGS(NUM_TRIGS), .NUM_GROUPS(NUM_GROUPS)
) u_checker (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
  .halt_evt(halt_evt), .halt_evt_id(halt_evt_id), .halted(halted),
  .trig_in(trig_in), .trig_out_ack(trig_out_ack),
  .grp_halt_irq(grp_halt_irq), .trig_out_req(trig_out_req),
  .hart_grp(hart_grp), .trig_grp(trig_grp)
);

// File: tb/halt_group_engine_bench.sv
`timescale 1ns/1ps
module halt_group_engine_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cfg_valid = 0, cfg_write = 0, cfg_sel_trig = 0;
  logic [2:0] cfg_group = 0;
  logic [0:0] cfg_trig_idx = 0;
  logic [3:0] hart_sel_mask = 0;
  logic [1:0] hart_sel_id = 0;
  logic [2:0] cfg_rd_group;
  logic       halt_evt = 0;
  logic [1:0] halt_evt_id = 0;
  logic [3:0] halted = 0;
  logic [1:0] trig_in = 0, trig_out_ack = 0;
  logic [3:0] grp_halt_irq;
  logic [1:0] trig_out_req;

  halt_group_engine u_halt_group_engine (.*);

  always #2 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  int mh[4], mt[2];
  bit mf[4];
  bit mprev[2];

  function automatic bit exp_irq(int h);   return mf[mh[h]]; endfunction
  function automatic bit exp_trig(int t);  return mf[mt[t]]; endfunction
  function automatic int exp_rd();
    return cfg_sel_trig ? mt[cfg_trig_idx] : mh[hart_sel_id];
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit nf[4];
    bit wr;
    for (int g = 1; g < 4; g++) begin
      bit hit = 0, allh = 1, alla = 1;
      if (halt_evt && !halted[halt_evt_id] && mh[halt_evt_id] == g) hit = 1;
      for (int h = 0; h < 4; h++) if (mh[h] == g && !halted[h]) allh = 0;
      for (int t = 0; t < 2; t++) if (mt[t] == g) begin
        if (trig_in[t] && !mprev[t]) hit = 1;
        if (!trig_out_ack[t]) alla = 0;
      end
      if (mf[g] && allh && alla) nf[g] = 0;
      else if (hit) nf[g] = 1;
      else nf[g] = mf[g];
    end
    nf[0] = 0;
    wr = cfg_valid && cfg_write && cfg_group < 4;
    if (wr && !cfg_sel_trig)
      for (int h = 0; h < 4; h++) if (hart_sel_mask[h]) mh[h] = cfg_group;
    if (wr && cfg_sel_trig) mt[cfg_trig_idx] = cfg_group;
    for (int t = 0; t < 2; t++) mprev[t] = trig_in[t];
    mf = nf;
  endtask

  task automatic compare_all(string req);
    for (int h = 0; h < 4; h++) check(req, $sformatf("irq[%0d]", h), grp_halt_irq[h], exp_irq(h));
    for (int t = 0; t < 2; t++) check(req, $sformatf("trig_out[%0d]", t), trig_out_req[t], exp_trig(t));
    check(req, "rd_group", cfg_rd_group, exp_rd());
  endtask

  task automatic tick(string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic idle_in();
    cfg_valid = 0; cfg_write = 0; halt_evt = 0;
  endtask

  task automatic cfg(bit wr, bit sel_t, int grp, int idx, int mask);
    cfg_valid = 1; cfg_write = wr; cfg_sel_trig = sel_t;
    cfg_group = 3'(grp); cfg_trig_idx = 1'(idx); hart_sel_mask = 4'(mask);
  endtask

  task automatic read_hart(string req, int h, int exp);
    cfg_sel_trig = 0; hart_sel_id = 2'(h); #0.5;
    check(req, $sformatf("hart%0d group", h), cfg_rd_group, exp);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) mh[i] = 0;
    mt[0] = 0; mt[1] = 0; mf = '{default:0}; mprev = '{default:0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    compare_all("R1");
    cfg_sel_trig = 1; #0.5; check("R1", "trig group", cfg_rd_group, 0);
    // R2 hart group write to harts 0 and 2
    cfg(1, 0, 2, 0, 4'b0101); tick("R2"); idle_in();
    read_hart("R2", 0, 2); read_hart("R2", 1, 0); read_hart("R2", 2, 2);
    // R3 trigger 1 into group 2
    cfg(1, 1, 2, 1, 0); tick("R3"); idle_in();
    cfg_sel_trig = 1; cfg_trig_idx = 1; #0.5; check("R3", "trig1 group", cfg_rd_group, 2);
    cfg_trig_idx = 0; #0.5; check("R3", "trig0 group", cfg_rd_group, 0);
    // R4 read-only access and out-of-range value
    cfg(0, 0, 3, 0, 4'b1111); tick("R4"); idle_in();
    read_hart("R4", 1, 0);
    cfg(1, 0, 5, 0, 4'b1111); tick("R4"); idle_in();
    read_hart("R4", 0, 2); read_hart("R4", 3, 0);
    // R5 read hart 3 after setting group 3; R10 setup
    cfg(1, 0, 3, 0, 4'b1000); tick("R5"); idle_in();
    read_hart("R5", 3, 3);
    // R6 fresh halt of hart 0 fires group 2
    halt_evt = 1; halt_evt_id = 0; tick("R6"); idle_in();
    check("R6", "reporter irq", grp_halt_irq[0], 1);
    check("R6", "peer irq", grp_halt_irq[2], 1);
    check("R6", "trig1 out", trig_out_req[1], 1);
    check("R10", "other group irq", grp_halt_irq[3], 0);
    check("R9", "group0 hart irq", grp_halt_irq[1], 0);
    // R8 all harts halted but ack missing: stays
    halted = 4'b0101; tick("R8"); tick("R8");
    check("R8", "held w/o ack", grp_halt_irq[2], 1);
    trig_out_ack = 2'b10; tick("R8");
    check("R8", "cleared irq", grp_halt_irq[0], 0);
    check("R8", "cleared trig", trig_out_req[1], 0);
    trig_out_ack = 0;
    // R6 event for already-halted hart: no fire
    halt_evt = 1; halt_evt_id = 2; tick("R6"); idle_in();
    check("R6", "stale event", grp_halt_irq[2], 0);
    // R7 rising trigger fires, held level does not refire
    trig_in = 2'b10; tick("R7");
    check("R7", "edge fire", grp_halt_irq[0], 1);
    trig_out_ack = 2'b10; tick("R7");
    check("R7", "cleared", trig_out_req[1], 0);
    tick("R7"); tick("R7");
    check("R7", "level no refire", trig_out_req[1], 0);
    trig_in = 0; trig_out_ack = 0; tick("R7");
    // R9 hart in group 0 reports halt
    halted = 0; halt_evt = 1; halt_evt_id = 1; tick("R9"); idle_in();
    check("R9", "group0 no irq", grp_halt_irq, 0);
    halt_evt = 1; halt_evt_id = 3; tick("R10"); idle_in();
    check("R10", "group3 irq", grp_halt_irq, 4'b1000);
    halted = 4'b1000; tick("R8"); halted = 0;
    // random phase
    for (int i = 0; i < 4000; i++) begin
      cfg_valid = ($urandom % 8) == 0;
      cfg_write = $urandom % 2; cfg_sel_trig = $urandom % 2;
      cfg_group = 3'($urandom % 6); cfg_trig_idx = 1'($urandom);
      hart_sel_mask = 4'($urandom); hart_sel_id = 2'($urandom);
      halt_evt = ($urandom % 4) == 0; halt_evt_id = 2'($urandom);
      if ($urandom % 3 == 0) halted[$urandom % 4] ^= 1'b1;
      if ($urandom % 6 == 0) trig_in[$urandom % 2] ^= 1'b1;
      trig_out_ack = 2'($urandom);
      tick("R8");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule